// File: doc/BRIEF.md
# LSB-Justified Stereo Serial Audio Receiver

This block takes a stereo audio stream carried on three wires: a bit clock, a word-select line and one serial data line. The stream is right-aligned, meaning each channel word ends on the last bit clock before word-select changes level. The block runs entirely in the bit-clock domain. It samples data on every rising bit-clock edge and rebuilds one 16-bit two's-complement sample for the left channel and one for the right channel.

A small selector sets how long the incoming words are. When a word is longer than 16 bits, the receiver keeps its 16 most significant bits. When fewer bits arrive than the selected length, the missing upper bits read as zero. The left word is parked in a holding register until the matching right word completes. Both samples then move to the outputs on the same edge, together with a one-cycle strobe. The downstream converter therefore sees both channels change at the same moment.

Top module: `lsbj_stereo_rx`

## Requirements
- R1: The serial line is sampled on every rising edge of `bck_i`. Each word is sent most significant bit first, and its 16-bit result is a two's-complement value.
- R2: Bits taken while `ws_i` is 1 form the left word, and bits taken while `ws_i` is 0 form the right word. The bit sampled on the last edge before `ws_i` changes is the least significant bit of the word that is ending. The bit sampled on the first edge after the change already belongs to the next word.
- R3: `wlen_i` selects the word length N: 0 selects 16, 1 selects 18, 2 selects 20 and 3 selects 24. At the edge that ends a word, the result is the upper 16 of the last N bits received, and the remaining low-order bits are dropped.
- R4: If a word delivers fewer than N bits, the bit positions not received are read as zero. The received bits remain aligned to the least significant end of the N-bit window.
- R5: `left_o`, `right_o` and `update_o` change only at the edge where `ws_i` is first sampled as 1 after a complete left word and a complete right word. At that edge `left_o` takes the held left word and `right_o` takes the right word that just ended. `update_o` is 1 for exactly the one following cycle.
- R6: Asserting `rst_ni` low clears `left_o`, `right_o` and `update_o` to 0 at once. The reset release takes effect two `bck_i` edges later. The first edge after that only records the `ws_i` level. No update occurs until a rising transition, a falling transition and another rising transition of `ws_i` have all been seen.
- R7: Between updates, `left_o` and `right_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck_i | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| ws_i | input | 1 | Word select: 1 marks the left word, 0 marks the right word |
| sdata_i | input | 1 | Serial data, most significant bit first |
| wlen_i | input | 2 | Word-length code (0:16, 1:18, 2:20, 3:24 bits) |
| left_o | output | 16 | Left-channel sample, two's complement |
| right_o | output | 16 | Right-channel sample, two's complement |
| update_o | output | 1 | One-cycle strobe marking a simultaneous update of both samples |

## Verification
Both samples and the strobe are registered at the `bck_i` edge where `ws_i` is first sampled as 1. They are visible from the following falling edge, and the strobe lasts only that one cycle. Leaving reset costs two edges in the synchronizer and one more edge to record the word-select level. The bench's behavioural model advances on each rising edge with these same latencies, and its results are compared on the next falling edge. Separately, every sample pair sent is queued with the value expected from the requirements alone. Each pair is checked when the strobe appears one word later, and any strobe with nothing queued counts as a failure.

// File: rtl/lsbj_rx_pkg.sv
package lsbj_rx_pkg;

  // Frame tracking: hunt for a clean left start, inside left, inside right
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_LEFT  = 2'd1,
    ST_RIGHT = 2'd2
  } frame_st_e;

  // Number of bits beyond the sample width for each length code
  function automatic int unsigned wlen_extra(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/lsbj_rst_sync.sv
module lsbj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/lsbj_bit_capture.sv
module lsbj_bit_capture
  import lsbj_rx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SHREG_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                restart_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] word_o
);

  localparam int CNT_W  = $clog2(SHREG_W + 1);
  localparam int BASE_W = $clog2(SHREG_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SHREG_W);

  logic [SHREG_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SHREG_W-1:0] bit_valid;
  logic [SHREG_W-1:0] masked;
  logic [BASE_W-1:0]  base;

  // Next state: shift every edge; counter restarts at 1 on a word boundary
  always_comb begin
    shreg_d = {shreg_q[SHREG_W-2:0], sdata_i};
    if (restart_i) begin
      cnt_d = CNT_W'(1);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  // Only bits received in the current word are kept; older ones read as zero
  for (genvar i = 0; i < SHREG_W; i++) begin : g_mask
    assign bit_valid[i] = (CNT_W'(i) < cnt_q);
  end

  assign masked = shreg_q & bit_valid;

  // Upper SAMPLE_W bits of the last N bits: window starts at N - SAMPLE_W
  always_comb begin
    base   = BASE_W'(wlen_extra(wlen_i));
    word_o = masked[base +: SAMPLE_W];
  end

endmodule

// File: rtl/lsbj_frame_ctl.sv
module lsbj_frame_ctl
  import lsbj_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ws_i,
  output logic restart_o,
  output logic left_done_o,
  output logic commit_o
);

  logic      ws_q;
  logic      primed_q;
  frame_st_e st_q, st_d;
  logic      rise, fall;

  assign restart_o   = primed_q & (ws_i ^ ws_q);
  assign rise        = restart_o & ws_i;
  assign fall        = restart_o & ~ws_i;
  assign left_done_o = fall;
  assign commit_o    = rise & (st_q == ST_RIGHT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HUNT:  if (rise) st_d = ST_LEFT;
      ST_LEFT:  if (fall) st_d = ST_RIGHT;
      ST_RIGHT: if (rise) st_d = ST_LEFT;
      default:  st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
      st_q     <= ST_HUNT;
    end else begin
      ws_q     <= ws_i;
      primed_q <= 1'b1;
      st_q     <= st_d;
    end
  end

endmodule

// File: rtl/lsbj_stereo_rx.sv
module lsbj_stereo_rx
  import lsbj_rx_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int SHREG_W    = 32,
  parameter int RST_STAGES = 2
) (
  input  logic                bck_i,
  input  logic                rst_ni,
  input  logic                ws_i,
  input  logic                sdata_i,
  input  logic [1:0]          wlen_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                update_o
);

  logic                rst_int_n;
  logic                restart, left_done, commit;
  logic [SAMPLE_W-1:0] word;

  logic [SAMPLE_W-1:0] hold_left_q, hold_left_d;
  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  logic                upd_q, upd_d;
  logic                hold_en, out_en;

  lsbj_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i   (bck_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_int_n)
  );

  lsbj_frame_ctl u_frame_ctl (
    .clk_i       (bck_i),
    .rst_ni      (rst_int_n),
    .ws_i        (ws_i),
    .restart_o   (restart),
    .left_done_o (left_done),
    .commit_o    (commit)
  );

  lsbj_bit_capture #(.SAMPLE_W(SAMPLE_W), .SHREG_W(SHREG_W)) u_capture (
    .clk_i     (bck_i),
    .rst_ni    (rst_int_n),
    .sdata_i   (sdata_i),
    .restart_i (restart),
    .wlen_i    (wlen_i),
    .word_o    (word)
  );

  assign hold_en = left_done;
  assign out_en  = commit;

  always_comb begin
    hold_left_d = hold_left_q;
    left_d      = left_q;
    right_d     = right_q;
    upd_d       = out_en;
    if (hold_en) hold_left_d = word;
    if (out_en) begin
      left_d  = hold_left_q;
      right_d = word;
    end
  end

  always_ff @(posedge bck_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_left_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
      upd_q       <= 1'b0;
    end else begin
      hold_left_q <= hold_left_d;
      left_q      <= left_d;
      right_q     <= right_d;
      upd_q       <= upd_d;
    end
  end

  assign left_o   = left_q;
  assign right_o  = right_q;
  assign update_o = upd_q;

endmodule

// File: rtl/lsbj_rx_chk.sv
module lsbj_rx_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ws_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                update_o
);

  // R5
  update_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  // R2
  update_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> ($past(ws_i, 1) && !$past(ws_i, 2)));

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> ($stable(left_o) && $stable(right_o)));

  // R6
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (left_o == '0 && right_o == '0 && !update_o));

endmodule

bind lsbj_stereo_rx lsbj_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i    (bck_i),
  .rst_ni   (rst_ni),
  .ws_i     (ws_i),
  .left_o   (left_o),
  .right_o  (right_o),
  .update_o (update_o)
);

// File: tb/lsbj_stereo_rx_tb_top.sv
`timescale 1ns/1ps
module lsbj_stereo_rx_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ws, din;
  logic [1:0]  wlen;
  logic [15:0] left, right;
  logic        upd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  lsbj_stereo_rx dut_i (
    .bck_i(clk), .rst_ni(rst_n), .ws_i(ws), .sdata_i(din), .wlen_i(wlen),
    .left_o(left), .right_o(right), .update_o(upd)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mq[$];
  int          rel;
  bit          primed, pws;
  int          st;
  logic [15:0] hl, m_l, m_r;
  bit          m_u;

  function automatic logic [15:0] mwin(input int n);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) begin
      int idx;
      idx  = mq.size() - 1 - (n - 16 + k);
      w[k] = (idx >= 0) ? mq[idx] : 1'b0;
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int n;
    logic [15:0] w;
    if (!rst_n) begin
      mq.delete(); rel = 0; primed = 0; pws = 0; st = 0;
      hl = '0; m_l = '0; m_r = '0; m_u = 0;
    end else if (rel < 2) begin
      rel++;
      m_u = 0;
    end else begin
      m_u = 0;
      n = 16 + ((wlen == 2'd0) ? 0 : (wlen == 2'd1) ? 2 : (wlen == 2'd2) ? 4 : 8);
      if (primed && (ws != pws)) begin
        w = mwin(n);
        if (!ws) begin
          hl = w;
          if (st == 1) st = 2;
        end else begin
          if (st == 2) begin
            m_l = hl; m_r = w; m_u = 1;
          end
          st = 1;
        end
        mq.delete();
        mq.push_back(din);
      end else begin
        mq.push_back(din);
        if (mq.size() > 32) void'(mq.pop_front());
      end
      pws = ws;
      primed = 1;
    end
  end

  // ---------------- expected frames from the requirements ----------------
  logic [15:0] exp_l[$], exp_r[$];
  string       exp_tag[$];

  task automatic push(input logic [15:0] l, input logic [15:0] r, input string tag);
    exp_l.push_back(l); exp_r.push_back(r); exp_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(left === m_l, "R7", "left vs model", int'(left), int'(m_l));
      chk(right === m_r, "R7", "right vs model", int'(right), int'(m_r));
      chk(upd === m_u, "R5", "strobe vs model", int'(upd), int'(m_u));
      if (upd === 1'b1) begin
        if (exp_l.size() == 0) begin
          chk(0, "R6", "strobe with no complete frame", 1, 0);
        end else begin
          logic [15:0] el, er;
          string t;
          el = exp_l.pop_front(); er = exp_r.pop_front(); t = exp_tag.pop_front();
          chk(left === el, t, "left sample", int'(left), int'(el));
          chk(right === er, t, "right sample", int'(right), int'(er));
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  // the new length code is applied with the second bit of the half
  task automatic send_half(input bit w, input logic [31:0] val, input int nbits,
                           input logic [1:0] wl);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); #1;
      ws  = w;
      din = val[i];
      if (i == nbits - 2) wlen = wl;
    end
  endtask

  task automatic send_frame(input logic [31:0] lv, input int lb,
                            input logic [31:0] rv, input int rb, input logic [1:0] wl);
    send_half(1'b1, lv, lb, wl);
    send_half(1'b0, rv, rb, wl);
  endtask

  initial begin
    rst_n = 1'b0; ws = 1'b1; din = 1'b0; wlen = 2'd0;
    repeat (4) @(negedge clk);
    chk(left === 16'h0 && right === 16'h0 && upd === 1'b0, "R6", "outputs in reset",
        int'({left, right}), 0);
    #1 rst_n = 1'b1;

    // partial left then a right word: no complete frame yet (R6)
    send_half(1'b1, 32'h1F, 5, 2'd0);
    send_half(1'b0, 32'h0BAD, 16, 2'd0);

    push(16'h1234, 16'hFEDC, "R1");
    send_frame(32'h1234, 16, 32'hFEDC, 16, 2'd0);
    push(16'h8000, 16'h7FFF, "R2");
    send_frame(32'h8000, 16, 32'h7FFF, 16, 2'd0);

    // 24-bit words, low byte dropped (R3)
    push(16'hA5C3, 16'h0F0F, "R3");
    send_frame({8'h0, 16'hA5C3, 8'h5A}, 24, {8'h0, 16'h0F0F, 8'hFF}, 24, 2'd3);
    // 32-bit words with 24 selected: bits 23..8 kept (R3)
    push(16'hADBE, 16'h3456, "R3");
    send_frame(32'hDEADBEEF, 32, 32'h12345678, 32, 2'd3);
    // 18-bit and 20-bit words (R3)
    push(16'h4321, 16'hC001, "R3");
    send_frame({14'h0, 16'h4321, 2'b11}, 18, {14'h0, 16'hC001, 2'b01}, 18, 2'd1);
    push(16'h7E7E, 16'h0001, "R3");
    send_frame({12'h0, 16'h7E7E, 4'h9}, 20, {12'h0, 16'h0001, 4'hF}, 20, 2'd2);
    // short 12-bit words with 20 selected: upper bits zero (R4)
    push(16'h00AB, 16'h0012, "R4");
    send_frame(32'hABC, 12, 32'h123, 12, 2'd2);

    // left start flushes the last frame, then reset mid-word
    send_half(1'b1, 32'hABCD, 16, 2'd0);
    @(negedge clk); #1;
    rst_n = 1'b0; ws = 1'b0;
    exp_l.delete(); exp_r.delete(); exp_tag.delete();
    @(negedge clk);
    chk(left === 16'h0 && right === 16'h0 && upd === 1'b0, "R6", "outputs after mid-run reset",
        int'({left, right}), 0);
    #1 rst_n = 1'b1;
    send_half(1'b0, 32'h0, 3, 2'd0);
    // first full frame after reset must come through (R6)
    push(16'h5555, 16'hAAAA, "R6");
    send_frame(32'h5555, 16, 32'hAAAA, 16, 2'd0);
    send_half(1'b1, 32'h0, 8, 2'd0);
    repeat (3) @(negedge clk);
    chk(exp_l.size() == 0, "R5", "frames left without a strobe", exp_l.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule